// File: doc/BRIEF.md
# Shared-Reference Physical Register Free List

This block hands out physical registers to a rename stage that folds register-to-register moves away. Ordinary destinations draw fresh registers from a circular queue of free register numbers. An eliminated move takes no new register: it receives the physical register its source already maps to, and that register gains one reference. Each physical register has a small reference count. Releases at commit remove one reference each, and a register goes back to the queue only when its last reference is gone.

Each rename lane presents a request with a move flag, the architectural source and destination, and the source's current physical register. The block answers within the same cycle with a grant, the chosen physical register, and whether the move was folded. Release lanes name physical registers whose references end. A redirect input suppresses all grants for the cycle and rewinds the queue's read pointer to a supplied value. The number of queued free registers is reported on every cycle.

Top module: `rcfl_freelist`

## Requirements
- R1: After reset, physical registers 0 to NUM_ARCH-1 hold one reference each, registers NUM_ARCH to NUM_PREGS-1 hold none, and the queue holds those unreferenced registers in ascending order, so free_count reads NUM_PREGS-NUM_ARCH and the first fresh grants are NUM_ARCH, NUM_ARCH+1.
- R2: Granted fresh lanes take registers from the queue head in lane order (lowest requesting fresh lane gets the oldest entry); each such grant adds one reference to the register taken.
- R3: A request with the move flag set and differing architectural source and destination is folded when the source register's count plus the number of lower lanes folding onto the same register in that cycle is below 2**CNT_W-1; it is then granted with alloc_elim high, alloc_preg equal to alloc_psrc, one reference added, and no queue entry consumed.
- R4: A move whose architectural source equals its destination is handled as a fresh allocation.
- R5: A move whose source register's count (including same-cycle lower-lane folds) has reached 2**CNT_W-1 falls back to a fresh allocation.
- R6: Fresh lanes are granted together only when free_count is at least the number of fresh-requesting lanes; otherwise none of them is granted, while folded lanes are granted regardless.
- R7: While redirect is high no lane is granted; on the next cycle the queue head equals redirect_head, which free_count shows as tail minus redirect_head.
- R8: Each valid release removes one reference; a register whose count reaches zero in that cycle is appended to the queue tail, several such registers in ascending lane order, and free_count rises on the next cycle.
- R9: When several release lanes name the same register in one cycle, all their references are removed, and the register is appended at most once.
- R10: Releases naming physical register 0 change neither its count nor the queue.
- R11: free_count equals the number of entries between head and tail, updated on the clock edge that applies grants, releases and redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | LANES | Per-lane rename request |
| alloc_move | input | LANES | Per-lane move flag |
| alloc_arch_src | input | LANES x ARCH_W | Architectural source of each lane |
| alloc_arch_dst | input | LANES x ARCH_W | Architectural destination of each lane |
| alloc_psrc | input | LANES x PW | Physical register currently mapped to the lane's source |
| alloc_grant | output | LANES | Lane granted this cycle |
| alloc_elim | output | LANES | Granted lane was folded onto its source register |
| alloc_preg | output | LANES x PW | Physical register handed to the lane |
| rel_valid | input | LANES | Per-lane release valid |
| rel_preg | input | LANES x PW | Register whose reference ends |
| redirect | input | 1 | Suppress grants and rewind the queue head |
| redirect_head | input | PW+1 | Head pointer (with wrap bit) to restore |
| free_count | output | PW+1 | Entries currently in the free queue |

## Verification
The bench uses the defaults: 64 physical registers, 32 architectural, 2 lanes and 2-bit counts. With two lanes a register reaches its count ceiling of 3 after a single cycle of double folding, so the fallback of R5 and the per-lane running total of R3 are both reached in a few cycles, and the same register can appear in both release lanes for R9. Thirty-two free entries drain in about sixteen cycles, which brings the one-entry and empty-queue cases of R6 and the reuse of pushed registers within reach of a short run.

// File: rtl/rcfl_pkg.sv
package rcfl_pkg;
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_FRESH = 2'd1,
    LK_ELIM  = 2'd2
  } lane_kind_e;
endpackage

// File: rtl/rcfl_refcnt.sv
module rcfl_refcnt #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  parameter int LANES     = 2,
  parameter int CNT_W     = 2,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int LW = $clog2(LANES + 1),
  localparam int SW = CNT_W + LW + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              inc_v,
  input  logic [LANES-1:0][PW-1:0]      inc_preg,
  input  logic [LANES-1:0]              dec_v,
  input  logic [LANES-1:0][PW-1:0]      dec_preg,
  output logic [NUM_PREGS-1:0][CNT_W-1:0] cnt_q,
  output logic [LANES-1:0]              push_v,
  output logic [LANES-1:0][PW-1:0]      push_preg
);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic [NUM_PREGS-1:0][LW-1:0]    inc_n, dec_n;
  logic [NUM_PREGS-1:0][CNT_W-1:0] cnt_d;
  logic [NUM_PREGS-1:0]            cnt_en;

  // per-register adder across lanes
  always_comb begin
    for (int r = 0; r < NUM_PREGS; r++) begin
      inc_n[r] = '0;
      dec_n[r] = '0;
      for (int k = 0; k < LANES; k++) begin
        if (inc_v[k] && inc_preg[k] == PW'(r)) inc_n[r] = inc_n[r] + LW'(1);
        if (dec_v[k] && dec_preg[k] == PW'(r) && r != 0) dec_n[r] = dec_n[r] + LW'(1);
      end
      cnt_d[r]  = CNT_W'(SW'(cnt_q[r]) + SW'(inc_n[r]) - SW'(dec_n[r]));
      cnt_en[r] = (inc_n[r] != '0) || (dec_n[r] != '0);
    end
  end

  // a register is pushed once, by the lowest lane naming it, when it hits zero
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic first;
      first = 1'b1;
      for (int j = 0; j < k; j++)
        if (dec_v[j] && dec_preg[j] == dec_preg[k]) first = 1'b0;
      push_v[k]    = dec_v[k] && (dec_preg[k] != '0) && first && (dec_n[dec_preg[k]] != '0)
                     && (cnt_d[dec_preg[k]] == '0);
      push_preg[k] = dec_preg[k];
    end
  end

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[r] <= (r < NUM_ARCH) ? CNT_W'(1) : '0;
      else if (cnt_en[r]) cnt_q[r] <= cnt_d[r];
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (SW'(cnt_q[r]) + SW'(inc_n[r])) <= SW'(CMAX));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rel_chk
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_v[k] && dec_preg[k] != '0) |-> (cnt_q[dec_preg[k]] != '0));
    for (genvar j = 0; j < k; j++) begin : g_pair
      p_single_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_v[j] && push_v[k]) |-> (push_preg[j] != push_preg[k]));
    end
  end
endmodule

// File: rtl/rcfl_queue.sv
module rcfl_queue #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  parameter int LANES     = 2,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int QW = PW + 1,
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LW-1:0]            pop_n,
  input  logic [LANES-1:0]         push_v,
  input  logic [LANES-1:0][PW-1:0] push_preg,
  input  logic                     rewind,
  input  logic [QW-1:0]            rewind_ptr,
  output logic [LANES-1:0][PW-1:0] rd_preg,
  output logic [QW-1:0]            free_n
);
  localparam int INIT_FREE = NUM_PREGS - NUM_ARCH;

  logic [NUM_PREGS-1:0][PW-1:0] mem_q, mem_d;
  logic [NUM_PREGS-1:0]         mem_we;
  logic [QW-1:0]                head_q, head_d, tail_q, tail_d;
  logic                         head_en, tail_en;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      rd_preg[k] = mem_q[head_q[PW-1:0] + PW'(k)];
  end

  assign free_n = tail_q - head_q;

  // compact the push lanes onto consecutive tail slots
  always_comb begin
    logic [LW-1:0] slot;
    slot   = '0;
    mem_we = '0;
    mem_d  = mem_q;
    for (int k = 0; k < LANES; k++) begin
      if (push_v[k]) begin
        mem_we[tail_q[PW-1:0] + PW'(slot)] = 1'b1;
        mem_d[tail_q[PW-1:0] + PW'(slot)]  = push_preg[k];
        slot = slot + LW'(1);
      end
    end
    tail_d  = tail_q + QW'(slot);
    tail_en = (slot != '0);
    head_d  = rewind ? rewind_ptr : head_q + QW'(pop_n);
    head_en = rewind || (pop_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= QW'(INIT_FREE);
    end else begin
      if (head_en) head_q <= head_d;
      if (tail_en) tail_q <= tail_d;
    end
  end

  for (genvar i = 0; i < NUM_PREGS; i++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[i] <= (i < INIT_FREE) ? PW'(NUM_ARCH + i) : '0;
      else if (mem_we[i]) mem_q[i] <= mem_d[i];
    end
  end

  p_pop_covered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rewind |-> (QW'(pop_n) <= free_n));
  p_free_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    free_n <= QW'(NUM_PREGS - 1));
endmodule

// File: rtl/rcfl_lane_ctl.sv
module rcfl_lane_ctl
  import rcfl_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int LANES     = 2,
  parameter int CNT_W     = 2,
  parameter int ARCH_W    = 5,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int QW = PW + 1,
  localparam int LW = $clog2(LANES + 1),
  localparam int SW = CNT_W + LW + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LANES-1:0]                 req,
  input  logic [LANES-1:0]                 is_move,
  input  logic [LANES-1:0][ARCH_W-1:0]     arch_src,
  input  logic [LANES-1:0][ARCH_W-1:0]     arch_dst,
  input  logic [LANES-1:0][PW-1:0]         psrc,
  input  logic [NUM_PREGS-1:0][CNT_W-1:0]  cnt_q,
  input  logic [LANES-1:0][PW-1:0]         rd_preg,
  input  logic [QW-1:0]                    free_n,
  input  logic                             redirect,
  output logic [LANES-1:0]                 grant,
  output logic [LANES-1:0]                 elim,
  output logic [LANES-1:0][PW-1:0]         preg,
  output logic [LW-1:0]                    pop_n
);
  localparam int CMAX = (1 << CNT_W) - 1;

  lane_kind_e [LANES-1:0]       kind;
  logic [LANES-1:0][LW-1:0]     slot;
  logic [LW-1:0]                n_fresh;
  logic                         fresh_ok;

  always_comb begin
    n_fresh = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [LW-1:0] prior;
      prior   = '0;
      kind[k] = LK_IDLE;
      slot[k] = '0;
      for (int j = 0; j < k; j++)
        if (kind[j] == LK_ELIM && psrc[j] == psrc[k]) prior = prior + LW'(1);
      if (req[k]) begin
        if (is_move[k] && arch_src[k] != arch_dst[k] &&
            (SW'(cnt_q[psrc[k]]) + SW'(prior)) < SW'(CMAX)) begin
          kind[k] = LK_ELIM;
        end else begin
          kind[k] = LK_FRESH;
          slot[k] = n_fresh;
          n_fresh = n_fresh + LW'(1);
        end
      end
    end
    fresh_ok = !redirect && (QW'(n_fresh) <= free_n);
    pop_n    = fresh_ok ? n_fresh : '0;
    for (int k = 0; k < LANES; k++) begin
      grant[k] = !redirect && ((kind[k] == LK_ELIM) || (kind[k] == LK_FRESH && fresh_ok));
      elim[k]  = grant[k] && (kind[k] == LK_ELIM);
      preg[k]  = (kind[k] == LK_ELIM) ? psrc[k] : rd_preg[slot[k]];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    p_same_arch_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req[k] && arch_src[k] == arch_dst[k]) |-> !elim[k]);
  end
endmodule

// File: rtl/rcfl_freelist.sv
module rcfl_freelist #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  parameter int LANES     = 2,
  parameter int CNT_W     = 2,
  parameter int ARCH_W    = 5,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int QW = PW + 1,
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             alloc_req,
  input  logic [LANES-1:0]             alloc_move,
  input  logic [LANES-1:0][ARCH_W-1:0] alloc_arch_src,
  input  logic [LANES-1:0][ARCH_W-1:0] alloc_arch_dst,
  input  logic [LANES-1:0][PW-1:0]     alloc_psrc,
  output logic [LANES-1:0]             alloc_grant,
  output logic [LANES-1:0]             alloc_elim,
  output logic [LANES-1:0][PW-1:0]     alloc_preg,
  input  logic [LANES-1:0]             rel_valid,
  input  logic [LANES-1:0][PW-1:0]     rel_preg,
  input  logic                         redirect,
  input  logic [QW-1:0]                redirect_head,
  output logic [QW-1:0]                free_count
);
  logic [NUM_PREGS-1:0][CNT_W-1:0] cnt_q;
  logic [LANES-1:0]                push_v;
  logic [LANES-1:0][PW-1:0]        push_preg;
  logic [LANES-1:0][PW-1:0]        rd_preg;
  logic [LW-1:0]                   pop_n;

  rcfl_lane_ctl #(.NUM_PREGS(NUM_PREGS), .LANES(LANES), .CNT_W(CNT_W), .ARCH_W(ARCH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req(alloc_req), .is_move(alloc_move), .arch_src(alloc_arch_src), .arch_dst(alloc_arch_dst),
    .psrc(alloc_psrc), .cnt_q(cnt_q), .rd_preg(rd_preg), .free_n(free_count),
    .redirect(redirect), .grant(alloc_grant), .elim(alloc_elim), .preg(alloc_preg), .pop_n(pop_n)
  );

  rcfl_refcnt #(.NUM_PREGS(NUM_PREGS), .NUM_ARCH(NUM_ARCH), .LANES(LANES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_v(alloc_grant), .inc_preg(alloc_preg),
    .dec_v(rel_valid), .dec_preg(rel_preg),
    .cnt_q(cnt_q), .push_v(push_v), .push_preg(push_preg)
  );

  rcfl_queue #(.NUM_PREGS(NUM_PREGS), .NUM_ARCH(NUM_ARCH), .LANES(LANES)) u_q (
    .clk(clk), .rst_n(rst_n),
    .pop_n(pop_n), .push_v(push_v), .push_preg(push_preg),
    .rewind(redirect), .rewind_ptr(redirect_head),
    .rd_preg(rd_preg), .free_n(free_count)
  );

  p_redirect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (alloc_grant == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    p_elim_reuses_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_elim[k] |-> (alloc_grant[k] && alloc_preg[k] == alloc_psrc[k]));
  end
endmodule

// File: tb/sim_rcfl_freelist.sv
`timescale 1ns/1ps
module sim_rcfl_freelist;
  localparam int NP = 64, NA = 32, L = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0]      req, mv, grant, elim, rv;
  logic [L-1:0][4:0] asrc, adst;
  logic [L-1:0][5:0] psrc, preg, rp;
  logic              redir;
  logic [6:0]        rhead, free_count;

  always #2 clk = ~clk;

  rcfl_freelist u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(req), .alloc_move(mv), .alloc_arch_src(asrc), .alloc_arch_dst(adst),
    .alloc_psrc(psrc), .alloc_grant(grant), .alloc_elim(elim), .alloc_preg(preg),
    .rel_valid(rv), .rel_preg(rp), .redirect(redir), .redirect_head(rhead),
    .free_count(free_count)
  );

  // behavioural model
  int cnt[NP];
  int fq[NP];
  int head, tail, rhead_i;
  int n_tests = 0, n_fail = 0;
  string cur_req;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic clr();
    req = '0; mv = '0; asrc = '0; adst = '0; psrc = '0; rv = '0; rp = '0;
    redir = 1'b0; rhead = '0; rhead_i = 0;
  endtask

  task automatic fresh(input int k);
    req[k] = 1'b1; mv[k] = 1'b0; asrc[k] = 5'd1; adst[k] = 5'd2;
  endtask

  task automatic move(input int k, input int s, input int d, input int p);
    req[k] = 1'b1; mv[k] = 1'b1; asrc[k] = 5'(s); adst[k] = 5'(d); psrc[k] = 6'(p);
  endtask

  task automatic rel(input int k, input int p);
    rv[k] = 1'b1; rp[k] = 6'(p);
  endtask

  // compare outputs against the model, then advance the model and the clock
  task automatic tick();
    int kind[L];
    int slot[L];
    int eg[L];
    int ep[L];
    int nf;
    bit fok;
    bit pushed[NP];
    #1;
    nf = 0;
    for (int k = 0; k < L; k++) begin
      int prior;
      prior = 0; kind[k] = 0; slot[k] = 0;
      for (int j = 0; j < k; j++) if (kind[j] == 2 && psrc[j] == psrc[k]) prior++;
      if (req[k]) begin
        if (mv[k] && asrc[k] != adst[k] && cnt[psrc[k]] + prior < 3) kind[k] = 2;
        else begin kind[k] = 1; slot[k] = nf; nf++; end
      end
    end
    fok = !redir && (tail - head >= nf);
    chk(int'(free_count) == tail - head, "free_count", int'(free_count), tail - head);
    for (int k = 0; k < L; k++) begin
      eg[k] = (!redir && (kind[k] == 2 || (kind[k] == 1 && fok))) ? 1 : 0;
      ep[k] = (kind[k] == 2) ? int'(psrc[k]) : fq[(head + slot[k]) % NP];
      chk(int'(grant[k]) == eg[k], $sformatf("grant lane%0d", k), int'(grant[k]), eg[k]);
      chk(int'(elim[k]) == (eg[k] && kind[k] == 2), $sformatf("elim lane%0d", k),
          int'(elim[k]), int'(eg[k] && kind[k] == 2));
      if (eg[k] == 1)
        chk(int'(preg[k]) == ep[k], $sformatf("preg lane%0d", k), int'(preg[k]), ep[k]);
    end
    for (int k = 0; k < L; k++) if (eg[k] == 1) cnt[ep[k]]++;
    if (redir) head = rhead_i;
    else if (fok) head += nf;
    for (int k = 0; k < L; k++) if (rv[k] && rp[k] != 0) cnt[rp[k]]--;
    for (int i = 0; i < NP; i++) pushed[i] = 0;
    for (int k = 0; k < L; k++)
      if (rv[k] && rp[k] != 0 && cnt[rp[k]] == 0 && !pushed[rp[k]]) begin
        pushed[rp[k]] = 1;
        fq[tail % NP] = int'(rp[k]);
        tail++;
      end
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      cnt[i] = (i < NA) ? 1 : 0;
      fq[i]  = (i < NP - NA) ? NA + i : 0;
    end
    head = 0; tail = NP - NA;
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then first fresh grants are 32 and 33
    cur_req = "R1";
    chk(free_count == 7'd32, "reset free_count", int'(free_count), 32);
    tick();
    fresh(0); fresh(1); tick(); clr();

    // R2: single fresh lane on lane1 takes the head entry
    cur_req = "R2";
    fresh(1); tick(); clr();

    // R3: folded move on lane0 next to a fresh lane1
    cur_req = "R3";
    move(0, 1, 2, 5); fresh(1); tick(); clr();

    // R4: move onto itself is a fresh allocation
    cur_req = "R4";
    move(0, 6, 6, 6); tick(); clr();

    // R3 running total and R5 fallback at the ceiling
    cur_req = "R3";
    move(0, 7, 8, 7); move(1, 7, 9, 7); tick(); clr();
    cur_req = "R5";
    move(0, 7, 10, 7); move(1, 11, 12, 11); tick(); clr();

    // R9: both lanes release the same register, no push (count 3 -> 1)
    cur_req = "R9";
    rel(0, 7); rel(1, 7); tick(); clr();
    tick();
    // R8: last reference gone, pushed
    cur_req = "R8";
    rel(0, 7); tick(); clr();
    tick();
    // R9: two references removed together and one push
    cur_req = "R9";
    rel(0, 5); rel(1, 5); tick(); clr();
    tick();
    // R10: register zero released on both lanes
    cur_req = "R10";
    rel(0, 0); rel(1, 0); tick(); clr();
    tick();
    // R8: two pushes in one cycle, lane order kept
    cur_req = "R8";
    rel(0, 13); rel(1, 12); tick(); clr();
    tick();

    // R7: allocate, then redirect back over it
    cur_req = "R7";
    begin
      int h_save;
      h_save = head;
      fresh(0); fresh(1); tick(); clr();
      fresh(0); fresh(1); redir = 1'b1; rhead = 7'(h_save % 128); rhead_i = h_save;
      tick(); clr();
      tick();
      fresh(0); fresh(1); tick(); clr();
    end

    // R6: drain the queue, then the one-entry and empty cases
    cur_req = "R6";
    while (tail - head >= 2) begin fresh(0); fresh(1); tick(); clr(); end
    if (tail - head == 1) begin
      fresh(0); fresh(1); tick(); clr();
      move(0, 3, 4, 3); fresh(1); tick(); clr();
    end
    move(0, 4, 5, 4); fresh(1); tick(); clr();
    fresh(0); tick(); clr();

    // R8/R11: refill two entries and drain them in push order
    cur_req = "R11";
    rel(0, 20); rel(1, 21); tick(); clr();
    tick();
    cur_req = "R8";
    fresh(0); fresh(1); tick(); clr();
    tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule